// File: doc/BRIEF.md
# Host-to-Processor DMA Request FIFO

This block connects a 16-bit host register bus to a processor-side DMA channel. The host opens a transfer by setting a length and an enable bit, then writes data words into a small FIFO through a single data port. The processor configures one DMA channel with a source address, a destination address, a word count, a mode field and a global enable. When the FIFO holds a whole number of 4-word groups and the channel is set up for FIFO transfers, the channel drains the FIFO. It writes each word to processor memory at increasing 16-bit addresses and counts down the host length and the channel count.

Completion is reported on both sides, and each side uses its own condition. The host enable bit drops when the host length reaches zero. The channel's transfer-end flag rises when the channel count reaches zero. A drain can start in two ways: a host push that lands the FIFO on a 4-word boundary, or a processor write that enables the channel while full groups are already waiting and the source register points at the FIFO port.

Memory writes leave on a valid/ready stream. `mem_valid` asks for a write of `mem_data` at `mem_addr`. The word moves on a cycle where `mem_ready` is also high. While `mem_ready` is low, the block holds `mem_valid`, the address and the data unchanged. The register write ports have no back-pressure. Host pushes that arrive during a drain are dropped.

Top module: `dreq_bridge`

## Requirements
- R1: A host write to the FIFO data port (`h_sel`=2) is dropped unless the host enable bit (bit 0 of the host control register, `h_sel`=0) is set.
- R2: A host write to the length register (`h_sel`=1) stores the value with bits 1:0 forced to zero.
- R3: A drain starts after a host push only when all of these hold: the host enable bit is set, the FIFO level is a non-zero multiple of 4, the channel mode (`ch_ctrl[1:0]`) equals 1, and the global enable (bit 0 of the operation register, `p_sel`=4) is set. Levels of 1 to 3, or any other mode, start nothing.
- R4: Each drained word is presented in FIFO order at address `ch_dst`. After the word is accepted, `ch_dst` grows by 2, and `ch_count` and `host_len` each drop by 1.
- R5: When a drain ends with `host_len` at zero, the host enable bit clears.
- R6: A drain stops when the FIFO is empty or `ch_count` reaches zero. Any words still in the FIFO are then discarded. If `ch_count` is zero at the end, the transfer-end flag `ch_ctrl[1]` is set.
- R7: `host_full` sets when the FIFO reaches its depth (8 words by default) and clears when a drain ends. Pushes made while the FIFO is full are dropped.
- R8: A processor write to the channel control register (`p_sel`=3) or the operation register (`p_sel`=4) starts a drain when R3's level, mode and enable conditions hold and the source register (`p_sel`=0) equals the FIFO port address.
- R9: When a drain starts, the channel count keeps only its low 24 bits.
- R10: A host write to the control register changes only the enable bit. `host_full` keeps its value.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R12: While a drain is in progress, processor writes to the destination register (`p_sel`=1) and the count register (`p_sel`=2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host register write strobe |
| h_sel | input | 2 | Host register select: 0 control, 1 length, 2 FIFO data port |
| h_wdata | input | 16 | Host write data |
| p_wr | input | 1 | Processor register write strobe |
| p_sel | input | 3 | Processor register select: 0 source, 1 destination, 2 count, 3 channel control, 4 operation |
| p_wdata | input | 32 | Processor write data |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the current word |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 16 | Memory write data |
| host_xfer_en | output | 1 | Host enable bit |
| host_full | output | 1 | FIFO full status bit |
| host_len | output | 16 | Remaining host transfer length |
| ch_dst | output | 32 | Channel destination address |
| ch_count | output | 32 | Channel remaining word count |
| ch_ctrl | output | 32 | Channel control register (mode in bits 1:0, transfer-end flag in bit 1) |

## Verification
The drain is driven by several patterns, and each one tells apart a different decision:
- Push sequences that stop at 3 words and then reach 4 show whether the trigger respects the 4-word boundary.
- A wrong mode, a disabled host and a mismatched source address check each start condition on its own.
- A channel count smaller than the FIFO contents, and a count with bits set above bit 23, show the early stop, the discard of leftover words and the 24-bit truncation.
- A run with the memory side stalled, with register writes made during the stall, shows that the stream holds steady and that the drain owns its counters.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  typedef enum logic [1:0] {
    HREG_CTRL = 2'd0,
    HREG_LEN  = 2'd1,
    HREG_PORT = 2'd2
  } hreg_e;

  typedef enum logic [2:0] {
    PREG_SRC = 3'd0,
    PREG_DST = 3'd1,
    PREG_CNT = 3'd2,
    PREG_CTL = 3'd3,
    PREG_OP  = 3'd4
  } preg_e;

  localparam logic [1:0] CH_MODE_FIFO = 2'd1;
  localparam int         CH_END_BIT   = 1;
  localparam int         HCTL_EN_BIT  = 0;

endpackage

// File: rtl/dreq_fifo.sv
module dreq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  input  logic          clear,
  output logic [CW-1:0] level,
  output logic [W-1:0]  head
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_push = push && (level != CW'(DEPTH));
  assign do_pop  = pop && (level != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

endmodule

// File: rtl/dreq_host_regs.sv
module dreq_host_regs
  import dreq_pkg::*;
#(
  parameter int HW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [HW-1:0] wdata,
  input  logic          busy,
  input  logic [CW-1:0] level,
  input  logic          len_dec,
  input  logic          drain_done,
  output logic          xfer_en,
  output logic          full,
  output logic [HW-1:0] len,
  output logic          push
);

  logic wr_ctrl, wr_len, wr_port;

  assign wr_ctrl = wr && (sel == HREG_CTRL);
  assign wr_len  = wr && (sel == HREG_LEN);
  assign wr_port = wr && (sel == HREG_PORT);
  assign push    = wr_port && xfer_en && !busy && (level != CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_en <= 1'b0;
      full    <= 1'b0;
      len     <= '0;
    end else begin
      if (wr_ctrl)                         xfer_en <= wdata[HCTL_EN_BIT];
      else if (drain_done && len == '0)    xfer_en <= 1'b0;

      if (drain_done)                                full <= 1'b0;
      else if (push && level == CW'(DEPTH - 1))      full <= 1'b1;

      if (wr_len)       len <= {wdata[HW-1:2], 2'b00};
      else if (len_dec) len <= len - HW'(1);
    end
  end

  p_len_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_len |=> len[1:0] == 2'b00);

  p_en_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done && len == '0 && !wr_ctrl) |=> !xfer_en);

  p_full_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !drain_done) |=> full == $past(full));

endmodule

// File: rtl/dreq_chan.sv
module dreq_chan
  import dreq_pkg::*;
#(
  parameter int AW                  = 32,
  parameter int CNT_BITS            = 24,
  parameter int BURST               = 4,
  parameter int DEPTH               = 8,
  parameter logic [AW-1:0] PORT_ADDR = 32'h2000_4012,
  localparam int CW                 = $clog2(DEPTH + 1),
  localparam logic [AW-1:0] CNT_MASK = AW'((64'd1 << CNT_BITS) - 64'd1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_wr,
  input  logic [2:0]    p_sel,
  input  logic [AW-1:0] p_wdata,
  input  logic          host_xfer_en,
  input  logic          push,
  input  logic [CW-1:0] level,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          pop,
  output logic          len_dec,
  output logic          drain_done,
  output logic          busy,
  output logic [AW-1:0] dst,
  output logic [AW-1:0] cnt,
  output logic [AW-1:0] ctl
);

  logic [AW-1:0] src;
  logic          op_en;
  logic          push_evt, cfg_evt;
  logic          aligned, armed, start, fire, finish, end_hit;
  logic          wr_src, wr_dst, wr_cnt, wr_ctl, wr_op;

  assign wr_src = p_wr && (p_sel == PREG_SRC);
  assign wr_dst = p_wr && (p_sel == PREG_DST);
  assign wr_cnt = p_wr && (p_sel == PREG_CNT);
  assign wr_ctl = p_wr && (p_sel == PREG_CTL);
  assign wr_op  = p_wr && (p_sel == PREG_OP);

  assign aligned = (level != '0) && ((int'(level) % BURST) == 0);
  assign armed   = (ctl[1:0] == CH_MODE_FIFO) && op_en;
  assign start   = !busy && aligned && armed &&
                   ((push_evt && host_xfer_en) || (cfg_evt && src == PORT_ADDR));

  assign mem_valid  = busy && (level != '0) && (cnt != '0);
  assign fire       = mem_valid && mem_ready;
  assign finish     = busy && !mem_valid;
  assign end_hit    = finish && (cnt == '0);
  assign pop        = fire;
  assign len_dec    = fire;
  assign drain_done = finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      push_evt <= 1'b0;
      cfg_evt  <= 1'b0;
      src      <= '0;
      op_en    <= 1'b0;
      ctl      <= '0;
      dst      <= '0;
      cnt      <= '0;
    end else begin
      push_evt <= push;
      cfg_evt  <= wr_ctl || wr_op;

      if (start)       busy <= 1'b1;
      else if (finish) busy <= 1'b0;

      if (wr_src) src   <= p_wdata;
      if (wr_op)  op_en <= p_wdata[0];

      if (wr_ctl)       ctl <= p_wdata | (end_hit ? (AW'(1) << CH_END_BIT) : '0);
      else if (end_hit) ctl[CH_END_BIT] <= 1'b1;

      if (fire)                 dst <= dst + AW'(2);
      else if (wr_dst && !busy) dst <= p_wdata;

      if (start)                cnt <= cnt & CNT_MASK;
      else if (fire)            cnt <= cnt - AW'(1);
      else if (wr_cnt && !busy) cnt <= p_wdata;
    end
  end

  p_dst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> dst == $past(dst) + AW'(2));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt == $past(cnt) - AW'(1));

  p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && !wr_ctl) |=> ctl[CH_END_BIT]);

  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt & ~CNT_MASK) == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(dst));

  p_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> (dst == $past(dst)) && (cnt == $past(cnt)));

endmodule

// File: rtl/dreq_bridge.sv
module dreq_bridge
  import dreq_pkg::*;
#(
  parameter int AW                   = 32,
  parameter int HW                   = 16,
  parameter int DEPTH                = 8,
  parameter int BURST                = 4,
  parameter int CNT_BITS             = 24,
  parameter logic [AW-1:0] PORT_ADDR = 32'h2000_4012
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic [1:0]    h_sel,
  input  logic [HW-1:0] h_wdata,
  input  logic          p_wr,
  input  logic [2:0]    p_sel,
  input  logic [AW-1:0] p_wdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [HW-1:0] mem_data,
  output logic          host_xfer_en,
  output logic          host_full,
  output logic [HW-1:0] host_len,
  output logic [AW-1:0] ch_dst,
  output logic [AW-1:0] ch_count,
  output logic [AW-1:0] ch_ctrl
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] level;
  logic          push, pop, len_dec, drain_done, busy;

  dreq_host_regs #(.HW(HW), .DEPTH(DEPTH)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (h_wr),
    .sel        (h_sel),
    .wdata      (h_wdata),
    .busy       (busy),
    .level      (level),
    .len_dec    (len_dec),
    .drain_done (drain_done),
    .xfer_en    (host_xfer_en),
    .full       (host_full),
    .len        (host_len),
    .push       (push)
  );

  dreq_fifo #(.W(HW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (h_wdata),
    .pop   (pop),
    .clear (drain_done),
    .level (level),
    .head  (mem_data)
  );

  dreq_chan #(
    .AW(AW), .CNT_BITS(CNT_BITS), .BURST(BURST), .DEPTH(DEPTH), .PORT_ADDR(PORT_ADDR)
  ) u_chan (
    .clk          (clk),
    .rst_n        (rst_n),
    .p_wr         (p_wr),
    .p_sel        (p_sel),
    .p_wdata      (p_wdata),
    .host_xfer_en (host_xfer_en),
    .push         (push),
    .level        (level),
    .mem_ready    (mem_ready),
    .mem_valid    (mem_valid),
    .pop          (pop),
    .len_dec      (len_dec),
    .drain_done   (drain_done),
    .busy         (busy),
    .dst          (ch_dst),
    .cnt          (ch_count),
    .ctl          (ch_ctrl)
  );

  assign mem_addr = ch_dst;

  p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_full |-> (level == CW'(DEPTH)) || busy);

  p_push_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_sel == HREG_PORT && !host_xfer_en && !busy) |=> level == $past(level));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_data) && $stable(mem_addr));

endmodule

// File: tb/test_dreq_bridge.sv
module test_dreq_bridge;

  localparam logic [31:0] PORT = 32'h2000_4012;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0;
  logic [1:0]  h_sel = '0;
  logic [15:0] h_wdata = '0;
  logic        p_wr = 1'b0;
  logic [2:0]  p_sel = '0;
  logic [31:0] p_wdata = '0;
  logic        mem_ready = 1'b1;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic        host_xfer_en, host_full;
  logic [15:0] host_len;
  logic [31:0] ch_dst, ch_count, ch_ctrl;

  int n_run = 0;
  int n_fail = 0;
  int mon_n = 0;
  logic [31:0] cap_addr [64];
  logic [15:0] cap_data [64];

  always #5 clk = ~clk;

  dreq_bridge i_dreq_bridge (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_sel(h_sel), .h_wdata(h_wdata),
    .p_wr(p_wr), .p_sel(p_sel), .p_wdata(p_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .host_xfer_en(host_xfer_en), .host_full(host_full), .host_len(host_len),
    .ch_dst(ch_dst), .ch_count(ch_count), .ch_ctrl(ch_ctrl)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && mem_valid && mem_ready) begin
      cap_addr[mon_n % 64] = mem_addr;
      cap_data[mon_n % 64] = mem_data;
      mon_n = mon_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_sel = s; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic pw(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    p_wr = 1'b1; p_sel = s; p_wdata = d;
    @(negedge clk);
    p_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] cnt, input logic [31:0] ctl);
    pw(3'd0, src);
    pw(3'd1, dst);
    pw(3'd2, cnt);
    pw(3'd4, 32'd1);
    pw(3'd3, ctl);
  endtask

  task automatic t_reset();
    do_reset();
    idle(1);
    chk("R5 reset enable", {31'd0, host_xfer_en}, 32'd0);
    chk("R7 reset full", {31'd0, host_full}, 32'd0);
    chk("R11 reset valid", {31'd0, mem_valid}, 32'd0);
    chk("R6 reset ctrl", ch_ctrl, 32'd0);
  endtask

  task automatic t_len_align();
    do_reset();
    hw(2'd1, 16'h0013);
    idle(1);
    chk("R2 length low bits", {16'd0, host_len}, 32'h10);
  endtask

  task automatic t_enable_gate();
    int base;
    do_reset();
    setup(32'd0, 32'h100, 32'd8, 32'd1);
    hw(2'd1, 16'd8);
    base = mon_n;
    for (int i = 0; i < 4; i++) hw(2'd2, 16'hA000 + 16'(i));
    idle(10);
    chk("R1 disabled push drains nothing", 32'(mon_n - base), 32'd0);
    hw(2'd0, 16'h0001);
    for (int i = 0; i < 4; i++) hw(2'd2, 16'hB000 + 16'(i));
    idle(12);
    chk("R1 only enabled words drained", 32'(mon_n - base), 32'd4);
    chk("R1 first word", {16'd0, cap_data[base % 64]}, 32'hB000);
  endtask

  task automatic t_main_drain();
    int base;
    do_reset();
    setup(32'd0, 32'h0600_0000, 32'd8, 32'd1);
    hw(2'd1, 16'd8);
    hw(2'd0, 16'h0001);
    base = mon_n;
    for (int i = 0; i < 3; i++) hw(2'd2, 16'hC000 + 16'(i));
    idle(8);
    chk("R3 three words no drain", 32'(mon_n - base), 32'd0);
    hw(2'd2, 16'hC003);
    idle(12);
    chk("R3 boundary drain count", 32'(mon_n - base), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 address order", cap_addr[(base + i) % 64], 32'h0600_0000 + 32'(2 * i));
      chk("R4 data order", {16'd0, cap_data[(base + i) % 64]}, 32'hC000 + 32'(i));
    end
    chk("R4 dst advanced", ch_dst, 32'h0600_0008);
    chk("R4 count", ch_count, 32'd4);
    chk("R4 length", {16'd0, host_len}, 32'd4);
    chk("R5 enable kept", {31'd0, host_xfer_en}, 32'd1);
    chk("R6 no end flag yet", ch_ctrl, 32'd1);
    for (int i = 0; i < 4; i++) hw(2'd2, 16'hC100 + 16'(i));
    idle(12);
    chk("R5 enable cleared at length zero", {31'd0, host_xfer_en}, 32'd0);
    chk("R6 end flag set", ch_ctrl, 32'd3);
    chk("R6 count zero", ch_count, 32'd0);
  endtask

  task automatic t_cfg_trigger();
    int base;
    do_reset();
    setup(PORT, 32'h200, 32'd8, 32'd2);
    hw(2'd1, 16'd8);
    hw(2'd0, 16'h0001);
    base = mon_n;
    for (int i = 0; i < 4; i++) hw(2'd2, 16'hD000 + 16'(i));
    idle(8);
    chk("R3 wrong mode no drain", 32'(mon_n - base), 32'd0);
    pw(3'd3, 32'd1);
    idle(12);
    chk("R8 control write drains", 32'(mon_n - base), 32'd4);
    do_reset();
    setup(32'h1234, 32'h300, 32'd8, 32'd0);
    hw(2'd1, 16'd8);
    hw(2'd0, 16'h0001);
    base = mon_n;
    for (int i = 0; i < 4; i++) hw(2'd2, 16'hE000 + 16'(i));
    pw(3'd3, 32'd1);
    idle(8);
    chk("R8 source mismatch no drain", 32'(mon_n - base), 32'd0);
    pw(3'd0, PORT);
    pw(3'd4, 32'd1);
    idle(12);
    chk("R8 operation write drains", 32'(mon_n - base), 32'd4);
    chk("R8 first word", {16'd0, cap_data[base % 64]}, 32'hE000);
  endtask

  task automatic t_full();
    int base;
    do_reset();
    setup(PORT, 32'h400, 32'd16, 32'd0);
    hw(2'd1, 16'd16);
    hw(2'd0, 16'h0001);
    base = mon_n;
    for (int i = 0; i < 8; i++) hw(2'd2, 16'hF000 + 16'(i));
    idle(1);
    chk("R7 full at depth", {31'd0, host_full}, 32'd1);
    hw(2'd2, 16'h9999);
    hw(2'd0, 16'h0001);
    idle(1);
    chk("R10 full kept on control write", {31'd0, host_full}, 32'd1);
    chk("R10 enable written", {31'd0, host_xfer_en}, 32'd1);
    pw(3'd3, 32'd1);
    idle(16);
    chk("R7 extra word dropped", 32'(mon_n - base), 32'd8);
    chk("R7 last word", {16'd0, cap_data[(base + 7) % 64]}, 32'hF007);
    chk("R7 full cleared", {31'd0, host_full}, 32'd0);
    chk("R4 count after eight", ch_count, 32'd8);
  endtask

  task automatic t_mask();
    int base;
    do_reset();
    setup(32'd0, 32'h500, 32'h0300_0004, 32'd1);
    hw(2'd1, 16'd4);
    hw(2'd0, 16'h0001);
    base = mon_n;
    for (int i = 0; i < 4; i++) hw(2'd2, 16'h1000 + 16'(i));
    idle(12);
    chk("R9 drained masked count", 32'(mon_n - base), 32'd4);
    chk("R9 count zero", ch_count, 32'd0);
    chk("R9 end flag", ch_ctrl, 32'd3);
  endtask

  task automatic t_early_stop();
    int base;
    do_reset();
    setup(32'd0, 32'h600, 32'd2, 32'd1);
    hw(2'd1, 16'd8);
    hw(2'd0, 16'h0001);
    base = mon_n;
    for (int i = 0; i < 4; i++) hw(2'd2, 16'h2000 + 16'(i));
    idle(12);
    chk("R6 stops at count zero", 32'(mon_n - base), 32'd2);
    chk("R6 end flag early", ch_ctrl, 32'd3);
    chk("R6 length", {16'd0, host_len}, 32'd6);
    pw(3'd2, 32'd4);
    pw(3'd3, 32'd1);
    base = mon_n;
    for (int i = 0; i < 2; i++) hw(2'd2, 16'h2100 + 16'(i));
    idle(8);
    chk("R6 leftovers discarded", 32'(mon_n - base), 32'd0);
    for (int i = 2; i < 4; i++) hw(2'd2, 16'h2100 + 16'(i));
    idle(12);
    chk("R6 fresh drain", 32'(mon_n - base), 32'd4);
    chk("R6 fresh first word", {16'd0, cap_data[base % 64]}, 32'h2100);
  endtask

  task automatic t_stall();
    int base;
    logic [15:0] d0;
    do_reset();
    setup(32'd0, 32'h700, 32'd4, 32'd1);
    hw(2'd1, 16'd4);
    hw(2'd0, 16'h0001);
    @(negedge clk);
    mem_ready = 1'b0;
    base = mon_n;
    for (int i = 0; i < 4; i++) hw(2'd2, 16'h3000 + 16'(i));
    idle(3);
    chk("R11 valid while stalled", {31'd0, mem_valid}, 32'd1);
    chk("R11 address while stalled", mem_addr, 32'h700);
    d0 = mem_data;
    pw(3'd1, 32'h9000);
    pw(3'd2, 32'd99);
    idle(2);
    chk("R11 still valid", {31'd0, mem_valid}, 32'd1);
    chk("R11 data stable", {16'd0, mem_data}, {16'd0, d0});
    chk("R12 dst write ignored", ch_dst, 32'h700);
    chk("R12 count write ignored", ch_count, 32'd4);
    @(negedge clk);
    mem_ready = 1'b1;
    idle(10);
    chk("R11 words after release", 32'(mon_n - base), 32'd4);
    chk("R11 first address", cap_addr[base % 64], 32'h700);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_len_align();
    t_enable_gate();
    t_main_drain();
    t_cfg_trigger();
    t_full();
    t_mask();
    t_early_stop();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule